// File: doc/BRIEF.md
# UART Receive Byte Queue with Break Insertion

This block is the small receive-side store of a UART. A deserializer hands it one byte at a time. The line side signals a detected break with a single-cycle pulse. The host register interface removes bytes, oldest first. The block keeps four bytes. When it is already full, a new arrival replaces the newest stored byte, so the most recent character is always kept.

Status comes out as registered flags: data-available, full, and a sticky break-change flag that the command logic clears. A break is stored as a 0x00 byte that travels the normal arrival path. A free-space output tells the sender how many more bytes fit. The output is forced to zero while the receiver is disabled, which holds back the sender without blocking arrivals that are already in flight. A flush input, driven by a receiver reset command, discards the stored bytes.

Top module: `rx_byte_queue`

## Requirements
- R1: Bytes leave the queue in arrival order, and it holds up to 4 of them.
- R2: `popData` presents the oldest stored byte at all times, and 0x00 while the queue is empty. A `popReq` on an empty queue changes no count or flag.
- R3: An arrival while the count is 4, with no removal in the same cycle, overwrites the newest stored byte, and the count stays 4.
- R4: `rxReady` is 1 exactly when the count is nonzero. Any arrival sets it, and a removal that empties the queue clears it.
- R5: `fifoFull` is 1 exactly when the count is 4. A removal clears it unless an arrival refills the queue in the same cycle.
- R6: A `breakPulse` sets `breakFlag` on the next cycle and stores a 0x00 byte. If `pushValid` is high in the same cycle, the data byte is dropped.
- R7: `breakClr` clears `breakFlag`. When `breakClr` and `breakPulse` coincide, the flag ends up set.
- R8: `freeSpace` equals 4 minus the count while `rxEnable` is 1, and 0 while it is 0. Arrivals are still stored while `rxEnable` is 0.
- R9: `flush` makes the count 0 and clears `rxReady` and `fifoFull` on the next cycle. It takes priority over an arrival or removal in the same cycle and leaves `breakFlag` alone.
- R10: When an arrival and a removal coincide, the removal is applied first. At count 4 the oldest byte leaves, the new byte is appended, and the count stays 4.
- R11: After reset the count is 0 and `rxReady`, `fifoFull` and `breakFlag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pushValid | input | 1 | Byte from the deserializer is valid this cycle |
| pushData | input | 8 | Received byte |
| breakPulse | input | 1 | Line break detected (single-cycle pulse) |
| popReq | input | 1 | Host removes the oldest byte |
| popData | output | 8 | Oldest stored byte, 0x00 when empty |
| flush | input | 1 | Receiver reset: discard stored bytes |
| breakClr | input | 1 | Clear the break-change flag |
| rxEnable | input | 1 | Receiver enabled; gates the free-space output |
| rxReady | output | 1 | At least one byte stored |
| fifoFull | output | 1 | Queue holds 4 bytes |
| breakFlag | output | 1 | Sticky break-change flag |
| freeSpace | output | 3 | Bytes that may still be sent, 0 when disabled |
| count | output | 3 | Number of stored bytes |

## Verification
The assertions check several relations on every cycle. The two status flags must track the count, and the count must never exceed 4. The free-space output must obey its enable gating. A flush must empty the queue, a break must raise the flag, and an arrival at full must leave the count at 4. The flags and the count come from separate pieces of logic, so these cross-checks have real content. Byte values are not covered by the assertions: the bench must show them through its scenarios. These cover arrival order, which byte the overwrite replaces, the 0x00 stored for a break, and the byte order after a removal and an arrival in the same cycle at full.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              pop;
    logic              push;
    logic              flush;
    logic [BYTE_W-1:0] data;
  } rxq_strobe_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  rxq_strobe_t                   stb,
  output logic [$clog2(DEPTH+1)-1:0]    count,
  output logic [BYTE_W-1:0]             headData
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rdPtr, newPtr, wrIdx;
  logic [CNT_W-1:0]  cntMid, cntNext;

  // Removal is applied first, then the arrival lands behind it.
  always_comb begin
    newPtr = rdPtr + PTR_W'(stb.pop);
    cntMid = count - CNT_W'(stb.pop);
    if (cntMid == CNT_W'(DEPTH)) begin
      wrIdx   = newPtr + PTR_W'(DEPTH - 1);   // newest slot is overwritten
      cntNext = cntMid;
    end else begin
      wrIdx   = newPtr + cntMid[PTR_W-1:0];
      cntNext = cntMid + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      count <= '0;
    end else if (stb.flush) begin
      rdPtr <= '0;
      count <= '0;
    end else begin
      rdPtr <= newPtr;
      count <= stb.push ? cntNext : cntMid;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.push && !stb.flush) mem[wrIdx] <= stb.data;
  end

  assign headData = (count == '0) ? '0 : mem[rdPtr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic                       pushValid,
  input  logic [BYTE_W-1:0]          pushData,
  input  logic                       breakPulse,
  input  logic                       popReq,
  input  logic                       flush,
  input  logic                       breakClr,
  output rxq_strobe_t                stb,
  output logic                       rxReady,
  output logic                       fifoFull,
  output logic                       breakFlag
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cntMid;

  always_comb begin
    stb.flush = flush;
    stb.pop   = popReq && (count != '0) && !flush;
    stb.push  = (pushValid || breakPulse) && !flush;
    stb.data  = breakPulse ? '0 : pushData;
    cntMid    = count - CNT_W'(stb.pop);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReady   <= 1'b0;
      fifoFull  <= 1'b0;
      breakFlag <= 1'b0;
    end else begin
      if (breakPulse)     breakFlag <= 1'b1;
      else if (breakClr)  breakFlag <= 1'b0;

      if (flush) begin
        rxReady  <= 1'b0;
        fifoFull <= 1'b0;
      end else begin
        if (stb.push)                               rxReady <= 1'b1;
        else if (stb.pop && count == CNT_W'(1))     rxReady <= 1'b0;

        if (stb.push && cntMid >= CNT_W'(DEPTH - 1)) fifoFull <= 1'b1;
        else if (stb.pop)                            fifoFull <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       pushValid,
  input  logic [7:0]                 pushData,
  input  logic                       breakPulse,
  input  logic                       popReq,
  output logic [7:0]                 popData,
  input  logic                       flush,
  input  logic                       breakClr,
  input  logic                       rxEnable,
  output logic                       rxReady,
  output logic                       fifoFull,
  output logic                       breakFlag,
  output logic [$clog2(DEPTH+1)-1:0] freeSpace,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  rxq_strobe_t stb;

  rxq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .count(count),
    .pushValid(pushValid), .pushData(pushData), .breakPulse(breakPulse),
    .popReq(popReq), .flush(flush), .breakClr(breakClr),
    .stb(stb), .rxReady(rxReady), .fifoFull(fifoFull), .breakFlag(breakFlag)
  );

  rxq_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .rstN(rstN), .stb(stb), .count(count), .headData(popData)
  );

  assign freeSpace = rxEnable ? (CNT_W'(DEPTH) - count) : '0;
endmodule

// File: rtl/rx_byte_queue_chk.sv
module rx_byte_queue_chk #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       pushValid,
  input logic                       breakPulse,
  input logic                       popReq,
  input logic                       flush,
  input logic                       rxEnable,
  input logic                       rxReady,
  input logic                       fifoFull,
  input logic                       breakFlag,
  input logic [$clog2(DEPTH+1)-1:0] freeSpace,
  input logic [$clog2(DEPTH+1)-1:0] count
);
  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    count <= DEPTH);

  p_empty_pop_still_r2: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && count == 0 && !pushValid && !breakPulse && !flush) |=> (count == 0));

  p_overwrite_keeps_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    (count == DEPTH && (pushValid || breakPulse) && !flush) |=> (count == DEPTH));

  p_ready_tracks_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    rxReady == (count != 0));

  p_full_tracks_count_r5: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull == (count == DEPTH));

  p_break_sets_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    breakPulse |=> breakFlag);

  p_free_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |-> (freeSpace == 0));

  p_free_value_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxEnable |-> (freeSpace == DEPTH - count));

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == 0 && !rxReady && !fifoFull));
endmodule

bind rx_byte_queue rx_byte_queue_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .pushValid(pushValid), .breakPulse(breakPulse),
  .popReq(popReq), .flush(flush), .rxEnable(rxEnable), .rxReady(rxReady),
  .fifoFull(fifoFull), .breakFlag(breakFlag), .freeSpace(freeSpace), .count(count)
);

// File: tb/rx_byte_queue_tb_top.sv
module rx_byte_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pushValid = 1'b0, breakPulse = 1'b0, popReq = 1'b0;
  logic       flush = 1'b0, breakClr = 1'b0, rxEnable = 1'b0;
  logic [7:0] pushData = '0;
  logic [7:0] popData;
  logic       rxReady, fifoFull, breakFlag;
  logic [2:0] freeSpace, count;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  logic [7:0] expQ [$];
  bit         expBrk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_byte_queue #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .breakPulse(breakPulse), .popReq(popReq), .popData(popData),
    .flush(flush), .breakClr(breakClr), .rxEnable(rxEnable),
    .rxReady(rxReady), .fifoFull(fifoFull), .breakFlag(breakFlag),
    .freeSpace(freeSpace), .count(count)
  );

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and updates the expected queue.
  // Monitor part: compares popData before the edge, state after it.
  task automatic cyc(string tag, bit pv, logic [7:0] pd, bit bk, bit pp,
                     bit fl, bit bc, bit en);
    logic [7:0] nb;
    @(negedge clk);
    pushValid = pv; pushData = pd; breakPulse = bk; popReq = pp;
    flush = fl; breakClr = bc; rxEnable = en;
    #1;
    chk(tag, "popData", popData, (expQ.size() == 0) ? 0 : expQ[0]);
    if (fl) expQ.delete();
    else begin
      if (pp && expQ.size() > 0) void'(expQ.pop_front());
      if (pv || bk) begin
        nb = bk ? 8'h00 : pd;
        if (expQ.size() == DEPTH) expQ[DEPTH-1] = nb;
        else expQ.push_back(nb);
      end
    end
    if (bk) expBrk = 1;
    else if (bc) expBrk = 0;
    @(posedge clk);
    #1;
    pushValid = 0; breakPulse = 0; popReq = 0; flush = 0; breakClr = 0;
    chk(tag, "count", count, expQ.size());
    chk(tag, "rxReady", rxReady, expQ.size() != 0);
    chk(tag, "fifoFull", fifoFull, expQ.size() == DEPTH);
    chk(tag, "breakFlag", breakFlag, expBrk);
    chk(tag, "freeSpace", freeSpace, en ? DEPTH - expQ.size() : 0);
  endtask

  task automatic drain(string tag);
    while (expQ.size() > 0) cyc(tag, 0, 0, 0, 1, 0, 0, 1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    chk("R11", "count", count, 0);
    chk("R11", "rxReady", rxReady, 0);
    chk("R11", "fifoFull", fifoFull, 0);
    chk("R11", "breakFlag", breakFlag, 0);
    @(negedge clk) rstN = 1;

    // R1: arrival order
    cyc("R1", 1, 8'h11, 0, 0, 0, 0, 1);
    cyc("R1", 1, 8'h22, 0, 0, 0, 0, 1);
    cyc("R1", 1, 8'h33, 0, 0, 0, 0, 1);
    drain("R1");
    // R2: removal on empty
    cyc("R2", 0, 0, 0, 1, 0, 0, 1);
    cyc("R2", 0, 0, 0, 1, 0, 0, 1);
    // R3/R5: fill, then overwrite newest
    for (int i = 0; i < 4; i++) cyc("R5", 1, 8'hA0 + 8'(i), 0, 0, 0, 0, 1);
    cyc("R3", 1, 8'h5C, 0, 0, 0, 0, 1);
    cyc("R3", 1, 8'h5D, 0, 0, 0, 0, 1);
    // R10: removal and arrival together at full
    cyc("R10", 1, 8'h77, 0, 1, 0, 0, 1);
    cyc("R5", 0, 0, 0, 1, 0, 0, 1);
    drain("R4");
    // R10 at empty
    cyc("R10", 1, 8'h42, 0, 1, 0, 0, 1);
    drain("R10");
    // R6: break with simultaneous data
    cyc("R6", 1, 8'hEE, 1, 0, 0, 0, 1);
    cyc("R6", 1, 8'h99, 0, 0, 0, 0, 1);
    drain("R6");
    // R7: clear, then clear coinciding with break
    cyc("R7", 0, 0, 0, 0, 0, 1, 1);
    cyc("R7", 0, 0, 1, 0, 0, 1, 1);
    cyc("R7", 0, 0, 0, 0, 0, 1, 1);
    drain("R7");
    // R8: disabled receiver still stores
    cyc("R8", 1, 8'h61, 0, 0, 0, 0, 0);
    cyc("R8", 1, 8'h62, 0, 0, 0, 0, 0);
    cyc("R8", 0, 0, 0, 0, 0, 0, 1);
    // R9: flush beats push and pop; break flag kept
    cyc("R9", 0, 0, 1, 0, 0, 0, 1);
    cyc("R9", 1, 8'h55, 0, 1, 1, 0, 1);
    cyc("R9", 0, 0, 0, 1, 0, 0, 1);
    // Mixed traffic
    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom_range(0, 99);
      cyc("R10", r < 55, 8'($urandom), r > 95, ($urandom_range(0, 2) == 0),
          r == 50, r == 7, r != 3);
    end
    drain("R1");

    done = 1;
    summary();
    $finish;
  end
endmodule